// File: doc/BRIEF.md
# PDM Microphone Front-End Control and Status Registers

This block is the software-visible register file of an eight-channel PDM microphone front end. A simple word-addressed bus (one write strobe, one read strobe, an 8-bit byte address and 32-bit data) reaches a small set of control, configuration and status words. The block turns those words into the enable, soft-reset, request-mode and channel-enable signals for the rest of the front end. It also holds the filter quality, oversampling and clock-divider settings.

The decimation filter, the sample FIFOs and any voice-activity logic sit outside. They report to this block through status inputs (filter busy, FIR output ready, a low-clock error event, per-channel new-data pulses and per-channel FIFO error events). Their channel samples are read through the data words. The block raises an interrupt or per-channel DMA requests, depending on the selected request mode. In DMA mode, reading a channel's data word acknowledges that channel's flag.

Top module: `pdm_csr`

## Requirements
- R1: After reset every word reads zero, except the FIFO-control word at 0x10, which reads 0x00000007. `irq_o`, `dma_req_o` and `soft_rst_o` are low after reset.
- R2: The control word at 0x00 stores these bits and reads them back: bit 31 disable, bit 30 doze, bit 29 enable, bit 28 debug, bit 26 debug-enable, bits 25:24 request select, bit 23 error-interrupt enable and bits 7:0 channel enables. All other bits read zero. `ch_en_o` follows bits 7:0, and `mod_en_o` is high only when bit 29 is set and bit 31 is clear.
- R3: Bit 27 of the control word always reads zero. When a write sets bit 27 while the stored disable bit 31 is 0, `soft_rst_o` is high for exactly the one cycle after that write, and all status flags are then cleared. When the stored disable bit is 1, such a write gives no pulse and leaves the flags unchanged.
- R4: The configuration word at 0x04 holds quality in bits 27:25, oversampling in bits 19:16 and clock divider in bits 7:0, driven on `qsel_o`, `osr_o` and `clkdiv_o`. A write to it is discarded entirely while `filt_busy_i` is high.
- R5: The status word at 0x08 reads `filt_busy_i` live in bit 31 and `fir_ready_i` live in bit 30. Bit 29 is a sticky low-clock flag set by `lowclk_evt_i`. Bits 7:0 are the per-channel data flags.
- R6: Status bits 29 and 7:0 are write-1-to-clear. Writing 0 to a bit leaves it unchanged, and writing to bits 31 and 30 has no effect.
- R7: A channel's data flag sets on a rising edge of its `ch_new_i` bit. An input held high sets the flag only once. If a rising edge and a write-1-to-clear of the same flag fall in the same cycle, the flag ends up set.
- R8: With request select 01 (DMA), a read of the channel-n data word at 0x24+4n clears flag n. With any other request select, such a read leaves the flag set.
- R9: `irq_o` is high when request select is 10 and any flag of an enabled channel is set, or when bit 23 is set and the low-clock flag is set. Request select 11 never raises the channel part.
- R10: `dma_req_o[n]` is high exactly when request select is 01 and flag n is set. Under 00, 10 and 11 it stays low.
- R11: The FIFO-control word at 0x10 holds a 3-bit watermark in bits 2:0, driven on `fifo_wmk_o`. The FIFO-status word at 0x14 holds per-channel sticky flags in bits 7:0, set by `fifo_evt_i` and write-1-to-clear.
- R12: The data word of channel n at 0x24+4n reads that channel's `ch_data_i` slice, zero-extended. A write to a data word changes no stored state.
- R13: A read of any other address, including unaligned ones, returns zero. A write to such an address changes no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one word per cycle |
| bus_rd_i | input | 1 | Read strobe; used for read side effects |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address, same cycle |
| filt_busy_i | input | 1 | Filter busy status |
| fir_ready_i | input | 1 | FIR output ready status |
| lowclk_evt_i | input | 1 | Filter clock too slow event |
| ch_new_i | input | NCH | Per-channel new-sample indication |
| ch_data_i | input | NCH*DATA_W | Channel samples, channel 0 in the low slice |
| fifo_evt_i | input | NCH | Per-channel FIFO error events |
| mod_en_o | output | 1 | Front end enabled |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |
| ch_en_o | output | NCH | Channel enables |
| qsel_o | output | 3 | Filter quality setting |
| osr_o | output | 4 | Oversampling setting |
| clkdiv_o | output | 8 | PDM clock divider |
| fifo_wmk_o | output | 3 | FIFO watermark |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | NCH | Per-channel DMA requests |

## Verification
On every cycle the assertions check several rules. DMA requests only appear under request select 01, and the interrupt only has an allowed source. The filter settings hold still while the filter is busy, and a rising new-data edge always leaves its flag set. The soft-reset pulse always follows a write of bit 27, that bit always reads zero, and unaligned addresses read zero. The bench scenarios cover what needs a history. These are the field layout and reset values, the disable bit gating the soft reset, and write-1-to-clear against set priority. They also cover the DMA-mode read acknowledgement compared with other modes, and writes to read-only and unmapped words leaving all state alone.

// File: rtl/pdm_csr_pkg.sv
// Shared constants and types for the PDM front-end register block.
// Assumes a byte-addressed bus with 32-bit words and at most 8 channels.
package pdm_csr_pkg;

    localparam int ADDR_W  = 8;
    localparam int WORD_W  = 32;
    localparam int CH_MAX  = 8;

    // word offsets
    localparam logic [ADDR_W-1:0] OFS_CTL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STS  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_FCTL = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_FSTS = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_DAT0 = 8'h24;

    // control word bit positions
    localparam int B_MDIS  = 31;
    localparam int B_DOZE  = 30;
    localparam int B_EN    = 29;
    localparam int B_DBG   = 28;
    localparam int B_SRES  = 27;
    localparam int B_DBGE  = 26;
    localparam int B_SEL   = 24;
    localparam int B_ERREN = 23;

    // status word bit positions
    localparam int B_BUSY  = 31;
    localparam int B_FIR   = 30;
    localparam int B_LOWF  = 29;

    // configuration word fields
    localparam int B_QSEL  = 25;
    localparam int QSEL_W  = 3;
    localparam int B_OSR   = 16;
    localparam int OSR_W   = 4;
    localparam int B_DIV   = 0;
    localparam int DIV_W   = 8;

    localparam int WMK_W   = 3;
    localparam logic [WMK_W-1:0] WMK_RST = '1;

    typedef enum logic [1:0] {
        REQ_NONE = 2'b00,
        REQ_DMA  = 2'b01,
        REQ_IRQ  = 2'b10,
        REQ_RSVD = 2'b11
    } req_sel_e;

    typedef struct packed {
        logic     mdis;
        logic     doze;
        logic     en;
        logic     dbg;
        logic     dbge;
        req_sel_e req_sel;
        logic     erren;
    } ctl_t;

    typedef struct packed {
        logic [QSEL_W-1:0] qsel;
        logic [OSR_W-1:0]  osr;
        logic [DIV_W-1:0]  div;
    } cfg_t;

endpackage

// File: rtl/pdm_csr_ctrl.sv
// Control, filter-configuration and FIFO-watermark storage.
// The soft-reset pulse is registered and gated by the stored disable bit
// (the value before the write). Configuration writes are dropped while the
// filter reports busy.
module pdm_csr_ctrl
    import pdm_csr_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_ctl_i,
    input  logic              wr_cfg_i,
    input  logic              wr_fctl_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              filt_busy_i,
    output ctl_t              ctl_o,
    output logic [NCH-1:0]    chen_o,
    output cfg_t              cfg_o,
    output logic [WMK_W-1:0]  wmk_o,
    output logic              srst_o
);

    ctl_t             ctl_q;
    logic [NCH-1:0]   chen_q;
    cfg_t             cfg_q;
    logic [WMK_W-1:0] wmk_q;
    logic             srst_q;

    // Control word register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q  <= '0;
            chen_q <= '0;
        end else if (wr_ctl_i) begin
            ctl_q.mdis    <= wdata_i[B_MDIS];
            ctl_q.doze    <= wdata_i[B_DOZE];
            ctl_q.en      <= wdata_i[B_EN];
            ctl_q.dbg     <= wdata_i[B_DBG];
            ctl_q.dbge    <= wdata_i[B_DBGE];
            ctl_q.req_sel <= req_sel_e'(wdata_i[B_SEL +: 2]);
            ctl_q.erren   <= wdata_i[B_ERREN];
            chen_q        <= wdata_i[NCH-1:0];
        end
    end

    // One-cycle soft reset, effective only when the stored disable bit is clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) srst_q <= 1'b0;
        else         srst_q <= wr_ctl_i && wdata_i[B_SRES] && !ctl_q.mdis;
    end

    // Filter configuration, locked while the filter is busy.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else if (wr_cfg_i && !filt_busy_i) begin
            cfg_q.qsel <= wdata_i[B_QSEL +: QSEL_W];
            cfg_q.osr  <= wdata_i[B_OSR  +: OSR_W];
            cfg_q.div  <= wdata_i[B_DIV  +: DIV_W];
        end
    end

    // FIFO watermark.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        wmk_q <= WMK_RST;
        else if (wr_fctl_i) wmk_q <= wdata_i[WMK_W-1:0];
    end

    logic unused_wbits;
    assign unused_wbits = ^wdata_i;

    assign ctl_o  = ctl_q;
    assign chen_o = chen_q;
    assign cfg_o  = cfg_q;
    assign wmk_o  = wmk_q;
    assign srst_o = srst_q;

endmodule

// File: rtl/pdm_csr_flags.sv
// Bank of sticky flags: set wins over a clear in the same cycle; clear
// comes from write-1-to-clear or another acknowledge; a soft reset clears all.
module pdm_csr_flags #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_all_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o
);

    logic [W-1:0] q;

    // Sticky flag update with set priority.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= ((clr_all_i ? '0 : q) & ~clr_i) | set_i;
    end

    assign flags_o = q;

endmodule

// File: rtl/pdm_csr_rdmux.sv
// Combinational read data selection. Unmapped and unaligned addresses
// return zero; reserved bits read zero.
module pdm_csr_rdmux
    import pdm_csr_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DATA_W = 24
) (
    input  logic [ADDR_W-1:0]     addr_i,
    input  ctl_t                  ctl_i,
    input  logic [NCH-1:0]        chen_i,
    input  cfg_t                  cfg_i,
    input  logic [WMK_W-1:0]      wmk_i,
    input  logic                  busy_i,
    input  logic                  fir_i,
    input  logic                  lowf_i,
    input  logic [NCH-1:0]        dflags_i,
    input  logic [NCH-1:0]        fflags_i,
    input  logic [NCH*DATA_W-1:0] ch_data_i,
    output logic [WORD_W-1:0]     rdata_o
);

    // Address decode and word assembly.
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFS_CTL: begin
                rdata_o[B_MDIS]      = ctl_i.mdis;
                rdata_o[B_DOZE]      = ctl_i.doze;
                rdata_o[B_EN]        = ctl_i.en;
                rdata_o[B_DBG]       = ctl_i.dbg;
                rdata_o[B_DBGE]      = ctl_i.dbge;
                rdata_o[B_SEL +: 2]  = ctl_i.req_sel;
                rdata_o[B_ERREN]     = ctl_i.erren;
                rdata_o[NCH-1:0]     = chen_i;
            end
            OFS_CFG: begin
                rdata_o[B_QSEL +: QSEL_W] = cfg_i.qsel;
                rdata_o[B_OSR  +: OSR_W]  = cfg_i.osr;
                rdata_o[B_DIV  +: DIV_W]  = cfg_i.div;
            end
            OFS_STS: begin
                rdata_o[B_BUSY]   = busy_i;
                rdata_o[B_FIR]    = fir_i;
                rdata_o[B_LOWF]   = lowf_i;
                rdata_o[NCH-1:0]  = dflags_i;
            end
            OFS_FCTL: rdata_o[WMK_W-1:0] = wmk_i;
            OFS_FSTS: rdata_o[NCH-1:0]   = fflags_i;
            default: begin
                for (int n = 0; n < NCH; n++) begin
                    if (addr_i == ADDR_W'(OFS_DAT0 + 4*n))
                        rdata_o[DATA_W-1:0] = ch_data_i[n*DATA_W +: DATA_W];
                end
            end
        endcase
    end

endmodule

// File: rtl/pdm_csr.sv
// PDM front-end register block top. Decodes bus strobes, detects rising
// new-data edges, keeps the sticky flag banks and forms the request outputs.
// Assumes NCH <= 8 and DATA_W <= 32; read data is valid in the same cycle.
module pdm_csr
    import pdm_csr_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DATA_W = 24
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  bus_wr_i,
    input  logic                  bus_rd_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [WORD_W-1:0]     bus_wdata_i,
    output logic [WORD_W-1:0]     bus_rdata_o,
    input  logic                  filt_busy_i,
    input  logic                  fir_ready_i,
    input  logic                  lowclk_evt_i,
    input  logic [NCH-1:0]        ch_new_i,
    input  logic [NCH*DATA_W-1:0] ch_data_i,
    input  logic [NCH-1:0]        fifo_evt_i,
    output logic                  mod_en_o,
    output logic                  soft_rst_o,
    output logic [NCH-1:0]        ch_en_o,
    output logic [QSEL_W-1:0]     qsel_o,
    output logic [OSR_W-1:0]      osr_o,
    output logic [DIV_W-1:0]      clkdiv_o,
    output logic [WMK_W-1:0]      fifo_wmk_o,
    output logic                  irq_o,
    output logic [NCH-1:0]        dma_req_o
);

    ctl_t             ctl;
    logic [NCH-1:0]   chen;
    cfg_t             cfg;
    logic [WMK_W-1:0] wmk;
    logic             srst;

    logic wr_ctl, wr_cfg, wr_sts, wr_fctl, wr_fsts;
    logic [NCH-1:0] dat_hit, dma_clr, ch_prev, ch_rise;
    logic [NCH-1:0] dflags, fflags, sts_w1c, fsts_w1c;
    logic           lowf;

    assign wr_ctl  = bus_wr_i && (bus_addr_i == OFS_CTL);
    assign wr_cfg  = bus_wr_i && (bus_addr_i == OFS_CFG);
    assign wr_sts  = bus_wr_i && (bus_addr_i == OFS_STS);
    assign wr_fctl = bus_wr_i && (bus_addr_i == OFS_FCTL);
    assign wr_fsts = bus_wr_i && (bus_addr_i == OFS_FSTS);

    // Per-channel data-word address match.
    for (genvar n = 0; n < NCH; n++) begin : g_dat
        assign dat_hit[n] = (bus_addr_i == ADDR_W'(OFS_DAT0 + 4*n));
    end

    assign dma_clr  = (bus_rd_i && ctl.req_sel == REQ_DMA) ? dat_hit : '0;
    assign sts_w1c  = wr_sts  ? bus_wdata_i[NCH-1:0] : '0;
    assign fsts_w1c = wr_fsts ? bus_wdata_i[NCH-1:0] : '0;

    // Previous new-data level for rising-edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) ch_prev <= '0;
        else         ch_prev <= ch_new_i;
    end
    assign ch_rise = ch_new_i & ~ch_prev;

    pdm_csr_ctrl #(.NCH(NCH)) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_ctl_i    (wr_ctl),
        .wr_cfg_i    (wr_cfg),
        .wr_fctl_i   (wr_fctl),
        .wdata_i     (bus_wdata_i),
        .filt_busy_i (filt_busy_i),
        .ctl_o       (ctl),
        .chen_o      (chen),
        .cfg_o       (cfg),
        .wmk_o       (wmk),
        .srst_o      (srst)
    );

    pdm_csr_flags #(.W(NCH)) u_dflags (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_all_i (srst),
        .set_i     (ch_rise),
        .clr_i     (sts_w1c | dma_clr),
        .flags_o   (dflags)
    );

    pdm_csr_flags #(.W(1)) u_lowf (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_all_i (srst),
        .set_i     (lowclk_evt_i),
        .clr_i     (wr_sts && bus_wdata_i[B_LOWF]),
        .flags_o   (lowf)
    );

    pdm_csr_flags #(.W(NCH)) u_fflags (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_all_i (srst),
        .set_i     (fifo_evt_i),
        .clr_i     (fsts_w1c),
        .flags_o   (fflags)
    );

    pdm_csr_rdmux #(.NCH(NCH), .DATA_W(DATA_W)) u_rdmux (
        .addr_i    (bus_addr_i),
        .ctl_i     (ctl),
        .chen_i    (chen),
        .cfg_i     (cfg),
        .wmk_i     (wmk),
        .busy_i    (filt_busy_i),
        .fir_i     (fir_ready_i),
        .lowf_i    (lowf),
        .dflags_i  (dflags),
        .fflags_i  (fflags),
        .ch_data_i (ch_data_i),
        .rdata_o   (bus_rdata_o)
    );

    assign mod_en_o   = ctl.en && !ctl.mdis;
    assign soft_rst_o = srst;
    assign ch_en_o    = chen;
    assign qsel_o     = cfg.qsel;
    assign osr_o      = cfg.osr;
    assign clkdiv_o   = cfg.div;
    assign fifo_wmk_o = wmk;
    assign irq_o      = ((ctl.req_sel == REQ_IRQ) && |(dflags & chen)) || (ctl.erren && lowf);
    assign dma_req_o  = (ctl.req_sel == REQ_DMA) ? dflags : '0;

endmodule

// File: rtl/pdm_csr_chk.sv
// Cycle-by-cycle property checker for pdm_csr, attached with bind.
module pdm_csr_chk
    import pdm_csr_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [WORD_W-1:0] bus_wdata_i,
    input logic [WORD_W-1:0] bus_rdata_i,
    input logic              filt_busy_i,
    input logic [QSEL_W-1:0] qsel_i,
    input logic [OSR_W-1:0]  osr_i,
    input logic [DIV_W-1:0]  clkdiv_i,
    input logic              irq_i,
    input logic [NCH-1:0]    dma_req_i,
    input logic [1:0]        req_sel_i,
    input logic              erren_i,
    input logic [NCH-1:0]    dflags_i,
    input logic [NCH-1:0]    rise_i,
    input logic              soft_rst_i
);

    logic unused_chk;
    assign unused_chk = ^bus_wdata_i;

    // R10: DMA requests only under request select 01
    a_r10_dma_mode_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_req_i != '0) |-> (req_sel_i == 2'b01));

    // R9: interrupt needs IRQ mode or the error enable
    a_r9_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> ((req_sel_i == 2'b10) || erren_i));

    // R4: filter settings hold while busy
    a_r4_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        filt_busy_i |=> $stable({qsel_i, osr_i, clkdiv_i}));

    // R7: a rising edge always leaves its flag set
    a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|rise_i) |=> ((dflags_i & $past(rise_i)) == $past(rise_i)));

    // R3: soft reset pulse only follows a control write with bit 27
    a_r3_srst_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_i |-> $past(bus_wr_i && (bus_addr_i == OFS_CTL) && bus_wdata_i[B_SRES]));

    // R3: self-clearing bit always reads zero
    a_r3_sres_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == OFS_CTL) |-> !bus_rdata_i[B_SRES]);

    // R13: unaligned addresses read zero
    a_r13_unaligned_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i[1:0] != 2'b00) |-> (bus_rdata_i == '0));

endmodule

bind pdm_csr pdm_csr_chk #(.NCH(NCH)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_i (bus_rdata_o),
    .filt_busy_i (filt_busy_i),
    .qsel_i      (qsel_o),
    .osr_i       (osr_o),
    .clkdiv_i    (clkdiv_o),
    .irq_i       (irq_o),
    .dma_req_i   (dma_req_o),
    .req_sel_i   (ctl.req_sel),
    .erren_i     (ctl.erren),
    .dflags_i    (dflags),
    .rise_i      (ch_rise),
    .soft_rst_i  (soft_rst_o)
);

// File: tb/pdm_csr_tb_top.sv
// Directed bench for pdm_csr: one task per scenario, each checks its results.
module pdm_csr_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 8;
    localparam int DATA_W     = 24;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]            bus_addr = '0;
    logic [31:0]           bus_wdata = '0;
    logic [31:0]           bus_rdata;
    logic                  filt_busy = 1'b0, fir_ready = 1'b0, lowclk_evt = 1'b0;
    logic [NCH-1:0]        ch_new = '0, fifo_evt = '0;
    logic [NCH*DATA_W-1:0] ch_data;
    logic                  mod_en, soft_rst, irq;
    logic [NCH-1:0]        ch_en, dma_req;
    logic [2:0]            qsel, wmk;
    logic [3:0]            osr;
    logic [7:0]            clkdiv;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // channel n sample value: 0xA00000 + 0x111*n
    function automatic logic [31:0] ch_val(input int n);
        return 32'h00A0_0000 + 32'(n * 32'h111);
    endfunction

    always_comb begin
        for (int n = 0; n < NCH; n++) ch_data[n*DATA_W +: DATA_W] = ch_val(n)[DATA_W-1:0];
    end

    pdm_csr #(.NCH(NCH), .DATA_W(DATA_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .filt_busy_i(filt_busy), .fir_ready_i(fir_ready), .lowclk_evt_i(lowclk_evt),
        .ch_new_i(ch_new), .ch_data_i(ch_data), .fifo_evt_i(fifo_evt),
        .mod_en_o(mod_en), .soft_rst_o(soft_rst), .ch_en_o(ch_en),
        .qsel_o(qsel), .osr_o(osr), .clkdiv_o(clkdiv), .fifo_wmk_o(wmk),
        .irq_o(irq), .dma_req_o(dma_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic pulse_new(input logic [NCH-1:0] m);
        @(negedge clk); ch_new = m;
        @(negedge clk); ch_new = '0;
    endtask

    task automatic pulse_low();
        @(negedge clk); lowclk_evt = 1'b1;
        @(negedge clk); lowclk_evt = 1'b0;
    endtask

    task automatic pulse_fifo(input logic [NCH-1:0] m);
        @(negedge clk); fifo_evt = m;
        @(negedge clk); fifo_evt = '0;
    endtask

    task automatic clr_all();
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        rd_chk("R1 ctl", 8'h00, 32'h0);
        rd_chk("R1 cfg", 8'h04, 32'h0);
        rd_chk("R1 sts", 8'h08, 32'h0);
        rd_chk("R1 fctl", 8'h10, 32'h7);
        rd_chk("R1 fsts", 8'h14, 32'h0);
        chk("R1 irq/dma/srst", {irq, dma_req, soft_rst}, '0);
    endtask

    task automatic t_ctl_fields();
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R2 ctl all ones", 8'h00, 32'hF780_00FF);
        chk("R2 ch_en", 32'(ch_en), 32'hFF);
        chk("R2 mod_en off when disabled", 32'(mod_en), 32'h0);
        wr(8'h00, 32'h2000_0005);
        chk("R2 mod_en on", 32'(mod_en), 32'h1);
        chk("R2 ch_en pattern", 32'(ch_en), 32'h05);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_soft_reset();
        clr_all();
        pulse_new(8'h03); pulse_low(); pulse_fifo(8'h10);
        wr(8'h00, 32'h8000_0000);
        wr(8'h00, 32'h8800_0000);
        chk("R3 no pulse while disabled", 32'(soft_rst), 32'h0);
        rd_chk("R3 flags kept", 8'h08, 32'h2000_0003);
        rd_chk("R3 fifo flags kept", 8'h14, 32'h10);
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h0800_0000);
        chk("R3 pulse", 32'(soft_rst), 32'h1);
        rd_chk("R3 sres reads zero", 8'h00, 32'h0);
        chk("R3 pulse one cycle", 32'(soft_rst), 32'h0);
        rd_chk("R3 flags cleared", 8'h08, 32'h0);
        rd_chk("R3 fifo flags cleared", 8'h14, 32'h0);
    endtask

    task automatic t_cfg_lock();
        wr(8'h04, 32'h0E0F_00AB);
        rd_chk("R4 cfg fields", 8'h04, 32'h0E0F_00AB);
        chk("R4 outputs", {20'h0, qsel, osr, clkdiv}, {20'h0, 3'h7, 4'hF, 8'hAB});
        filt_busy = 1'b1;
        wr(8'h04, 32'h0201_0011);
        rd_chk("R4 locked while busy", 8'h04, 32'h0E0F_00AB);
        rd_chk("R5 busy bit", 8'h08, 32'h8000_0000);
        filt_busy = 1'b0;
        wr(8'h04, 32'h0201_0011);
        rd_chk("R4 write after busy", 8'h04, 32'h0201_0011);
    endtask

    task automatic t_stat_w1c();
        clr_all();
        pulse_new(8'h05); pulse_low();
        fir_ready = 1'b1;
        rd_chk("R5 status fields", 8'h08, 32'h6000_0005);
        wr(8'h08, 32'h0);
        rd_chk("R6 zero write keeps", 8'h08, 32'h6000_0005);
        wr(8'h08, 32'h6000_0001);
        rd_chk("R6 w1c selected", 8'h08, 32'h4000_0004);
        fir_ready = 1'b0;
        rd_chk("R5 fir live", 8'h08, 32'h0000_0004);
    endtask

    task automatic t_set_wins();
        clr_all();
        pulse_new(8'h02);
        @(negedge clk);
        ch_new = 8'h02; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h2;
        @(negedge clk);
        ch_new = '0; bus_wr = 1'b0; bus_wdata = '0;
        rd_chk("R7 set wins over clear", 8'h08, 32'h2);
        wr(8'h08, 32'h2);
        @(negedge clk); ch_new = 8'h08;
        repeat (3) @(negedge clk);
        rd_chk("R7 held high sets", 8'h08, 32'h8);
        wr(8'h08, 32'h8);
        rd_chk("R7 held high sets once", 8'h08, 32'h0);
        ch_new = '0;
    endtask

    task automatic t_dma_irq();
        clr_all();
        wr(8'h00, 32'h0100_00FF);
        pulse_new(8'h06);
        chk("R10 dma req", 32'(dma_req), 32'h06);
        chk("R9 no irq in dma mode", 32'(irq), 32'h0);
        rd_chk("R12 data read ch1", 8'h28, ch_val(1));
        chk("R8 dma read clears", 32'(dma_req), 32'h04);
        wr(8'h00, 32'h0200_00FF);
        chk("R10 no dma in irq mode", 32'(dma_req), 32'h0);
        chk("R9 irq on flag", 32'(irq), 32'h1);
        rd_chk("R12 data read ch2", 8'h2C, ch_val(2));
        rd_chk("R8 irq mode read keeps", 8'h08, 32'h4);
        wr(8'h00, 32'h0200_00FB);
        chk("R9 disabled channel no irq", 32'(irq), 32'h0);
        wr(8'h00, 32'h0300_00FF);
        chk("R9 R10 reserved select quiet", {31'h0, irq} | 32'(dma_req), 32'h0);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_err_irq();
        clr_all();
        wr(8'h00, 32'h0080_0000);
        chk("R9 err irq idle", 32'(irq), 32'h0);
        pulse_low();
        chk("R9 err irq set", 32'(irq), 32'h1);
        wr(8'h08, 32'h2000_0000);
        chk("R9 err irq cleared", 32'(irq), 32'h0);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_fifo();
        wr(8'h10, 32'h3);
        rd_chk("R11 watermark", 8'h10, 32'h3);
        chk("R11 wmk out", 32'(wmk), 32'h3);
        wr(8'h10, 32'hFFFF_FFFF);
        rd_chk("R11 watermark width", 8'h10, 32'h7);
        clr_all();
        pulse_fifo(8'h81);
        rd_chk("R11 fifo flags", 8'h14, 32'h81);
        wr(8'h14, 32'h01);
        rd_chk("R11 fifo w1c", 8'h14, 32'h80);
    endtask

    task automatic t_ro_unmapped();
        clr_all();
        wr(8'h00, 32'h0000_0033);
        wr(8'h04, 32'h0000_0055);
        pulse_new(8'h10);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd_chk("R12 data word read", 8'h24, ch_val(0));
        rd_chk("R12 R13 ctl unchanged", 8'h00, 32'h33);
        rd_chk("R12 R13 cfg unchanged", 8'h04, 32'h55);
        rd_chk("R12 R13 sts unchanged", 8'h08, 32'h10);
        rd_chk("R12 R13 fctl unchanged", 8'h10, 32'h7);
        rd_chk("R13 gap reads zero", 8'h0C, 32'h0);
        rd_chk("R13 unaligned reads zero", 8'h25, 32'h0);
        rd_chk("R13 past last channel", 8'h44, 32'h0);
        rd_chk("R12 last channel", 8'h40, ch_val(7));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctl_fields();
        t_soft_reset();
        t_cfg_lock();
        t_stat_w1c();
        t_set_wins();
        t_dma_irq();
        t_err_irq();
        t_fifo();
        t_ro_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule